// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block holds the digital control for one microcontroller I/O port of eight pins. It follows the classic quasi-bidirectional scheme. Each pin has a port latch bit, and software can write that bit on its own or as part of a full byte. Each pin also has its own 3-bit function code. The code routes the pin to the latch or to a peripheral, and it sets the pin's drive mode: quasi-bidirectional, open-drain, push-pull or analog input. Each pin has four registered control outputs: a strong low-side driver enable, a strong high-side driver enable, a weak pull-up enable and an analog-input flag.

In quasi-bidirectional mode, a pin that rises from '0' to '1' gets the strong high-side driver for exactly one clock. After that, only the weak pull-up holds the pin high, so an external device can still pull it low. Software reads the latch contents back directly. The pad levels come back through a multi-flop synchronizer.

Top module: `qbport_ctrl`

## Requirements
- R1: Reset sets every latch bit to 1. On the first cycle after reset, with every function code at 0, each pin has its pull-up on and both strong drivers and the analog flag off.
- R2: When a pin's effective output is 0 and the pin is in the quasi-bidirectional, open-drain or push-pull mode, the low-side enable is 1 and the high-side enable is 0. The drive outputs change on the second clock edge after the latch write is sampled.
- R3: In quasi-bidirectional mode with an effective output of 1, the low-side enable is 0 and the pull-up is 1.
- R4: In quasi-bidirectional mode, the high-side enable is 1 for exactly one cycle after the effective output goes from 0 to 1. Writing 1 over a 1 produces no pulse.
- R5: Code 2 selects open-drain mode. The pin drives low only; the high-side enable and the pull-up stay 0.
- R6: Code 3 selects push-pull mode. While the effective output is 1, the high-side enable and the pull-up stay on for as long as that holds.
- R7: Code 5 selects analog mode. All drivers and the pull-up are off and the analog flag is 1. Leaving this mode gives no high pulse.
- R8: Code 4 (capture/timer input) forces the effective output to 1, whatever the latch holds, so the pin never drives low.
- R9: Function codes apply to each pin on its own. Codes 1, 2 and 3 take the pin's peripheral output ANDed with its latch bit as the effective output. Codes 0, 6 and 7 use the latch bit alone.
- R10: A byte write loads all latch bits on the next edge. A single-bit write changes only the pin at the given index. When both are asserted in the same cycle, the byte write wins. The latch read-back output shows the latch register.
- R11: Each bit of the pad read output equals the matching pad input as sampled two clock edges earlier.
- R12: When a pin's function code changes, the high pulse is judged against that pin's previous effective output. Moving from a function that drove low to a quasi-bidirectional '1' produces a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_we | input | 1 | Full latch write strobe |
| byte_wdata | input | NPINS | Data for a full latch write |
| bit_we | input | 1 | Single-bit latch write strobe |
| bit_sel | input | IDX_W | Index of the latch bit to write |
| bit_wval | input | 1 | Value for a single-bit write |
| fn_sel | input | NPINS*3 | Per-pin function code, pin i in bits [3i+2:3i] |
| alt_out | input | NPINS | Peripheral output bit for each pin |
| pad_in | input | NPINS | Pad input levels |
| latch_rdata | output | NPINS | Latch contents |
| pad_rdata | output | NPINS | Synchronized pad levels |
| drv_low | output | NPINS | Strong low-side driver enables |
| drv_high | output | NPINS | Strong high-side driver enables |
| pull_up | output | NPINS | Weak pull-up enables |
| analog_sel | output | NPINS | Analog-input flags |

## Verification
The bench uses the default build: NPINS = 8 and SYNC_STAGES = 2. With this build, all six function codes plus an unused code can sit on different pins in the same cycle, so the independence of each pin's mode is tested directly. The two-stage synchronizer makes the pad read latency exactly two cycles, which lets the bench check both the old value and the new one. Driving the peripheral outputs low on chosen pins exercises the gating by the latch, and it also exercises pulses that come from function changes rather than from writes.

// File: rtl/qbport_pkg.sv
package qbport_pkg;

  localparam int FN_W = 3;

  typedef enum logic [1:0] {
    DM_QUASI      = 2'd0,
    DM_OPEN_DRAIN = 2'd1,
    DM_PUSH_PULL  = 2'd2,
    DM_ANALOG     = 2'd3
  } dmode_e;

  localparam logic [FN_W-1:0] FC_GPIO    = 3'd0;
  localparam logic [FN_W-1:0] FC_SERIAL  = 3'd1;
  localparam logic [FN_W-1:0] FC_TWOWIRE = 3'd2;
  localparam logic [FN_W-1:0] FC_CMP_OUT = 3'd3;
  localparam logic [FN_W-1:0] FC_CAP_IN  = 3'd4;
  localparam logic [FN_W-1:0] FC_ANALOG  = 3'd5;

  function automatic dmode_e fn_to_mode(input logic [FN_W-1:0] code);
    case (code)
      FC_TWOWIRE: return DM_OPEN_DRAIN;
      FC_CMP_OUT: return DM_PUSH_PULL;
      FC_ANALOG:  return DM_ANALOG;
      default:    return DM_QUASI;
    endcase
  endfunction

  function automatic logic fn_uses_periph(input logic [FN_W-1:0] code);
    return (code == FC_SERIAL) || (code == FC_TWOWIRE) || (code == FC_CMP_OUT);
  endfunction

endpackage

// File: rtl/qbport_latch.sv
module qbport_latch #(
  parameter int NPINS = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_we,
  input  logic [NPINS-1:0] byte_wdata,
  input  logic             bit_we,
  input  logic [IDX_W-1:0] bit_sel,
  input  logic             bit_wval,
  output logic [NPINS-1:0] latch_q
);

  logic [NPINS-1:0] latch_d;

  for (genvar j = 0; j < NPINS; j++) begin : g_bit
    always_comb begin
      if (byte_we)
        latch_d[j] = byte_wdata[j];
      else if (bit_we && (int'(bit_sel) == j))
        latch_d[j] = bit_wval;
      else
        latch_d[j] = latch_q[j];
    end

    AST_BIT_WRITE_LOCAL: assert property (@(posedge clk) disable iff (rst)
      (bit_we && !byte_we && (int'(bit_sel) != j)) |=> $stable(latch_q[j])) // R10
      else $error("bit write touched pin %0d", j);
  end

  always_ff @(posedge clk) begin
    if (rst) latch_q <= '1;
    else     latch_q <= latch_d;
  end

  AST_RESET_ONES: assert property (@(posedge clk)
    rst |=> (latch_q == '1)) // R1
    else $error("latch not all ones after reset");

  AST_BYTE_LOAD: assert property (@(posedge clk) disable iff (rst)
    byte_we |=> (latch_q == $past(byte_wdata))) // R10
    else $error("byte write not loaded");

endmodule

// File: rtl/qbport_pin.sv
module qbport_pin
  import qbport_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [FN_W-1:0] fsel,
  input  logic            latch_bit,
  input  logic            periph_bit,
  output logic            low_q,
  output logic            high_q,
  output logic            pull_q,
  output logic            ana_q
);

  dmode_e mode, mode_q;
  logic   eff, track, prev_q;
  logic   low_d, high_d, pull_d, ana_d;

  assign mode  = fn_to_mode(fsel);
  assign eff   = (fsel == FC_CAP_IN) ? 1'b1
               : (latch_bit & (fn_uses_periph(fsel) ? periph_bit : 1'b1));
  // analog pins count as high so that leaving analog mode gives no pulse
  assign track = (mode == DM_ANALOG) ? 1'b1 : eff;

  always_comb begin
    low_d  = 1'b0;
    high_d = 1'b0;
    pull_d = 1'b0;
    ana_d  = 1'b0;
    case (mode)
      DM_QUASI: begin
        low_d  = !eff;
        pull_d = eff;
        high_d = eff && !prev_q;
      end
      DM_OPEN_DRAIN: low_d = !eff;
      DM_PUSH_PULL: begin
        low_d  = !eff;
        high_d = eff;
        pull_d = eff;
      end
      default: ana_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      low_q  <= 1'b0;
      high_q <= 1'b0;
      pull_q <= 1'b1;
      ana_q  <= 1'b0;
      mode_q <= DM_QUASI;
    end else begin
      prev_q <= track;
      low_q  <= low_d;
      high_q <= high_d;
      pull_q <= pull_d;
      ana_q  <= ana_d;
      mode_q <= mode;
    end
  end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
    !(low_q && high_q)) // R2
    else $error("both strong drivers on");

  AST_QUASI_HIGH_PULLS: assert property (@(posedge clk) disable iff (rst)
    (mode_q == DM_QUASI && !low_q) |-> pull_q) // R3
    else $error("quasi high without pull-up");

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (high_q && mode_q == DM_QUASI) |=> !(high_q && mode_q == DM_QUASI)) // R4
    else $error("quasi high pulse longer than one cycle");

  AST_OPEN_DRAIN_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
    (mode_q == DM_OPEN_DRAIN) |-> (!high_q && !pull_q)) // R5
    else $error("open-drain pin sourcing current");

  AST_ANALOG_QUIET: assert property (@(posedge clk) disable iff (rst)
    ana_q |-> (!low_q && !high_q && !pull_q)) // R7
    else $error("analog pin has a driver on");

  AST_CAPTURE_NEVER_LOW: assert property (@(posedge clk) disable iff (rst)
    (fsel == FC_CAP_IN) |=> !low_q) // R8
    else $error("capture input pin pulled low");

endmodule

// File: rtl/qbport_sync.sv
module qbport_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] d,
  output logic [NPINS-1:0] q
);

  logic [NPINS-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)         chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else             chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/qbport_ctrl.sv
module qbport_ctrl
  import qbport_pkg::*;
#(
  parameter  int NPINS       = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int IDX_W       = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  byte_we,
  input  logic [NPINS-1:0]      byte_wdata,
  input  logic                  bit_we,
  input  logic [IDX_W-1:0]      bit_sel,
  input  logic                  bit_wval,
  input  logic [NPINS*FN_W-1:0] fn_sel,
  input  logic [NPINS-1:0]      alt_out,
  input  logic [NPINS-1:0]      pad_in,
  output logic [NPINS-1:0]      latch_rdata,
  output logic [NPINS-1:0]      pad_rdata,
  output logic [NPINS-1:0]      drv_low,
  output logic [NPINS-1:0]      drv_high,
  output logic [NPINS-1:0]      pull_up,
  output logic [NPINS-1:0]      analog_sel
);

  logic [NPINS-1:0] latch_q;

  qbport_latch #(.NPINS(NPINS), .IDX_W(IDX_W)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .byte_we    (byte_we),
    .byte_wdata (byte_wdata),
    .bit_we     (bit_we),
    .bit_sel    (bit_sel),
    .bit_wval   (bit_wval),
    .latch_q    (latch_q)
  );

  assign latch_rdata = latch_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    qbport_pin u_pin (
      .clk        (clk),
      .rst        (rst),
      .fsel       (fn_sel[i*FN_W +: FN_W]),
      .latch_bit  (latch_q[i]),
      .periph_bit (alt_out[i]),
      .low_q      (drv_low[i]),
      .high_q     (drv_high[i]),
      .pull_q     (pull_up[i]),
      .ana_q      (analog_sel[i])
    );
  end

  qbport_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pad_rdata)
  );

endmodule

// File: tb/qbport_ctrl_test.sv
module qbport_ctrl_test;

  localparam int CLK_P = 10;
  localparam int NP    = 8;

  localparam int S_LATCH = 0;
  localparam int S_LOW   = 1;
  localparam int S_HIGH  = 2;
  localparam int S_PULL  = 3;
  localparam int S_ANA   = 4;
  localparam int S_PAD   = 5;

  typedef struct {
    int       cyc;
    int       sig;
    logic [7:0] val;
    string    req;
  } item_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            byte_we = 1'b0;
  logic [NP-1:0]   byte_wdata = '0;
  logic            bit_we = 1'b0;
  logic [2:0]      bit_sel = '0;
  logic            bit_wval = 1'b0;
  logic [NP*3-1:0] fn_sel = '0;
  logic [NP-1:0]   alt_out = '1;
  logic [NP-1:0]   pad_in = '0;
  logic [NP-1:0]   latch_rdata, pad_rdata, drv_low, drv_high, pull_up, analog_sel;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  item_t sbq[$];
  item_t sb_rest[$];

  qbport_ctrl #(.NPINS(NP), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .byte_we(byte_we), .byte_wdata(byte_wdata),
    .bit_we(bit_we), .bit_sel(bit_sel), .bit_wval(bit_wval), .fn_sel(fn_sel),
    .alt_out(alt_out), .pad_in(pad_in), .latch_rdata(latch_rdata),
    .pad_rdata(pad_rdata), .drv_low(drv_low), .drv_high(drv_high),
    .pull_up(pull_up), .analog_sel(analog_sel)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] sample(int sig);
    case (sig)
      S_LATCH: return latch_rdata;
      S_LOW:   return drv_low;
      S_HIGH:  return drv_high;
      S_PULL:  return pull_up;
      S_ANA:   return analog_sel;
      default: return pad_rdata;
    endcase
  endfunction

  // monitor: compares every item due in this cycle
  always @(negedge clk) begin
    sb_rest = {};
    foreach (sbq[i]) begin
      if (sbq[i].cyc == cyc) begin
        n_chk++;
        if (sample(sbq[i].sig) !== sbq[i].val) begin
          n_bad++;
          $display("FAIL %s sig=%0d cyc=%0d actual=%h expected=%h",
                   sbq[i].req, sbq[i].sig, cyc, sample(sbq[i].sig), sbq[i].val);
        end
      end else begin
        sb_rest.push_back(sbq[i]);
      end
    end
    sbq = sb_rest;
  end

  task automatic expect_at(int ofs, int sig, logic [7:0] v, string req);
    item_t it;
    it.cyc = cyc + ofs; it.sig = sig; it.val = v; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic wr_byte(logic [7:0] d);
    byte_we = 1'b1; byte_wdata = d;
    @(negedge clk);
    byte_we = 1'b0;
  endtask

  task automatic set_fn(int pin, logic [2:0] code);
    fn_sel[pin*3 +: 3] = code;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog cyc=%0d actual=hung expected=done", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    expect_at(1, S_LATCH, 8'hFF, "R1");
    expect_at(1, S_PULL,  8'hFF, "R1");
    expect_at(1, S_LOW,   8'h00, "R1");
    expect_at(1, S_HIGH,  8'h00, "R1");
    expect_at(1, S_ANA,   8'h00, "R1");
    repeat (2) @(negedge clk);

    // R10 byte load, R2/R3 drive levels, R4 no pulse on falling pins
    expect_at(1, S_LATCH, 8'hA5, "R10");
    expect_at(2, S_LOW,   8'h5A, "R2");
    expect_at(2, S_PULL,  8'hA5, "R3");
    expect_at(2, S_HIGH,  8'h00, "R4");
    wr_byte(8'hA5);
    @(negedge clk);

    // R4 one-cycle pulse on rising pins
    expect_at(2, S_HIGH, 8'h5A, "R4");
    expect_at(3, S_HIGH, 8'h00, "R4");
    expect_at(2, S_PULL, 8'hFF, "R3");
    expect_at(2, S_LOW,  8'h00, "R3");
    wr_byte(8'hFF);
    repeat (2) @(negedge clk);

    // R4 writing 1 over 1: no pulse
    expect_at(2, S_HIGH, 8'h00, "R4");
    wr_byte(8'hFF);
    repeat (2) @(negedge clk);

    // R10 single-bit write
    expect_at(1, S_LATCH, 8'hF7, "R10");
    expect_at(2, S_LOW,   8'h08, "R2");
    bit_we = 1'b1; bit_sel = 3'd3; bit_wval = 1'b0;
    @(negedge clk);
    bit_we = 1'b0;
    @(negedge clk);

    // R10 byte write wins over bit write
    expect_at(1, S_LATCH, 8'h00, "R10");
    byte_we = 1'b1; byte_wdata = 8'h00;
    bit_we = 1'b1; bit_sel = 3'd0; bit_wval = 1'b1;
    @(negedge clk);
    byte_we = 1'b0; bit_we = 1'b0;
    wr_byte(8'hFF);
    @(negedge clk);

    // R5 R6 R7 R9 mixed functions, latch all ones
    set_fn(0, 3'd2); set_fn(1, 3'd3); set_fn(2, 3'd4);
    set_fn(3, 3'd5); set_fn(4, 3'd7); set_fn(5, 3'd1);
    expect_at(1, S_HIGH, 8'h02, "R6");
    expect_at(1, S_LOW,  8'h00, "R5");
    expect_at(1, S_PULL, 8'hF6, "R9");
    expect_at(1, S_ANA,  8'h08, "R7");
    repeat (2) @(negedge clk);

    // R8 capture pin stays high with latch cleared
    expect_at(2, S_LOW,  8'hF3, "R8");
    expect_at(2, S_PULL, 8'h04, "R8");
    expect_at(2, S_HIGH, 8'h00, "R5");
    wr_byte(8'h00);
    repeat (2) @(negedge clk);

    // R9 peripheral output gating, R6 push-pull holds high
    alt_out = 8'hDE;
    expect_at(2, S_LOW,  8'h21, "R9");
    expect_at(2, S_PULL, 8'hD6, "R9");
    expect_at(2, S_HIGH, 8'hD2, "R4");
    expect_at(3, S_HIGH, 8'h02, "R6");
    wr_byte(8'hFF);
    repeat (2) @(negedge clk);

    // R12 pulse on function change out of a low state; R7 no pulse leaving analog
    set_fn(0, 3'd0); set_fn(3, 3'd0); set_fn(5, 3'd0);
    expect_at(1, S_HIGH, 8'h23, "R12");
    expect_at(2, S_HIGH, 8'h02, "R12");
    expect_at(1, S_LOW,  8'h00, "R12");
    expect_at(1, S_ANA,  8'h00, "R7");
    repeat (3) @(negedge clk);

    // R11 pad synchronizer latency
    pad_in = 8'h3C;
    expect_at(1, S_PAD, 8'h00, "R11");
    expect_at(2, S_PAD, 8'h3C, "R11");
    repeat (4) @(negedge clk);

    if (sbq.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard actual=%0d expected=0 pending items", sbq.size());
    end
    finish_run();
  end

endmodule